// File: doc/BRIEF.md
# Pseudo-Random Word Generator with Byte-Order Reversal

A small bus-mapped peripheral. It holds a 32-bit pseudo-random generator built as a shift register with feedback. Software seeds the generator and reads it at one register offset.

A control register chooses when the generator advances. In free-run mode it advances on every clock. In on-read mode it advances only after each read of its register. The same control register also selects the width of a byte-order reversal helper.

Software writes a 64-bit value as two 32-bit words. It then reads the value back with the byte order reversed, over either 32 or 64 bits. Two further read-only offsets return sample words from external entropy sources, which reach the block on input ports.

The bus is a simple single-cycle select/write interface. A write is captured at the rising clock edge while the block is selected. Read data is combinational from the address while the block is selected for a read.

Top module: `rng_swap_periph`

## Requirements
- R1: While reset is applied and until it is released, the generator reads as 0xACE12468, and the control register and both write-buffer words read as zero.
- R2: A read of offset 0x00 returns the current generator state. With control bit 0 clear, the state advances on every clock by s' = (s >> 1) XOR (s[0] ? 0x80200003 : 0).
- R3: With control bit 0 set, the state advances exactly once for each read of offset 0x00. The step takes effect after the read, and the state holds in every other cycle.
- R4: A write to offset 0x00 loads the written value as the new state, and this load wins over any step in the same cycle. A written value of zero loads 0xACE12468 instead, so the state is never zero.
- R5: Offset 0x04 holds control bits 5:0 (bit 0 selects the step mode, bit 1 selects the swap width, bits 2 to 5 are plain storage). Bits 31:6 read as zero, and a new control value takes effect from the next cycle.
- R6: Offsets 0x08 (bytes 0 to 3, byte 0 in bits 7:0) and 0x0C (bytes 4 to 7, byte 4 in bits 7:0) are read/write buffer words.
- R7: Offset 0x10 reads the reversal result. With control bit 1 set, bytes 7,6,5,4 appear in lanes 7:0, 15:8, 23:16 and 31:24. With control bit 1 clear, bytes 3,2,1,0 appear in those lanes.
- R8: Offset 0x14 always reads bytes 3,2,1,0 in lanes 7:0, 15:8, 23:16 and 31:24.
- R9: Offset 0x18 reads the latch-source sample input, and offset 0x1C reads the white-noise sample input, both unchanged.
- R10: Writes to offsets 0x10, 0x14, 0x18, 0x1C or to unmapped addresses change no readable state. A read of any address other than the eight mapped offsets returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Peripheral selected for an access this cycle |
| bus_write | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | ADDR_W (32) | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while selected for a read |
| latch_word_i | input | 32 | Sample word from the latch entropy source |
| noise_word_i | input | 32 | Sample word from the white-noise entropy source |

## Verification
A wrong generator state shows at offset 0x00 on the very next read. Because the step function is a permutation of the nonzero states, a single wrong bit never heals, and every later value diverges. A step mode that is decoded wrongly shows within one cycle: in on-read mode, two reads separated by idle cycles must differ by exactly one step, and in free-run mode each clock must move the state. Buffer and swap faults appear at once on the next read of 0x10 or 0x14, with a byte misplaced by lane.

// File: rtl/rng_periph_pkg.sv
package rng_periph_pkg;
  localparam int REG_W   = 32;
  localparam int BYTE_W  = 8;

  localparam logic [7:0] OFF_RAND   = 8'h00;
  localparam logic [7:0] OFF_CTRL   = 8'h04;
  localparam logic [7:0] OFF_WBUF_L = 8'h08;
  localparam logic [7:0] OFF_WBUF_H = 8'h0C;
  localparam logic [7:0] OFF_RBUF_L = 8'h10;
  localparam logic [7:0] OFF_RBUF_H = 8'h14;
  localparam logic [7:0] OFF_LATCH  = 8'h18;
  localparam logic [7:0] OFF_NOISE  = 8'h1C;

  typedef struct packed {
    logic spare;
    logic src_latch_en;
    logic noise_en;
    logic fast_speed;
    logic swap_wide;
    logic step_on_read;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
  parameter int              W       = 32,
  parameter logic [W-1:0]    TAPS    = 32'h80200003,
  parameter logic [W-1:0]    DEFAULT = 32'hACE12468
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         step_en,
  output logic [W-1:0] state
);
  logic [W-1:0] stepped;
  logic [W-1:0] seed_fixed;
  logic [W-1:0] state_d;
  logic         state_en;

  always_comb begin
    stepped    = {1'b0, state[W-1:1]} ^ (state[0] ? TAPS : '0);
    seed_fixed = (load_val == '0) ? DEFAULT : load_val;
    state_en   = load_en | step_en;
    if (load_en) state_d = seed_fixed;
    else         state_d = stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state <= DEFAULT;
    else if (state_en) state <= state_d;
  end
endmodule

// File: rtl/rng_byteswap.sv
module rng_byteswap #(
  parameter int W = 32
) (
  input  logic         wide,
  input  logic [W-1:0] lo_word,
  input  logic [W-1:0] hi_word,
  output logic [W-1:0] rd_lo,
  output logic [W-1:0] rd_hi
);
  localparam int NB = W / 8;

  logic [W-1:0] rev_lo;
  logic [W-1:0] rev_hi;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign rev_lo[8*i +: 8] = lo_word[8*(NB-1-i) +: 8];
    assign rev_hi[8*i +: 8] = hi_word[8*(NB-1-i) +: 8];
  end

  assign rd_lo = wide ? rev_hi : rev_lo;
  assign rd_hi = rev_lo;
endmodule

// File: rtl/rng_swap_periph.sv
module rng_swap_periph
  import rng_periph_pkg::*;
#(
  parameter int          ADDR_W       = 32,
  parameter logic [31:0] LFSR_TAPS    = 32'h80200003,
  parameter logic [31:0] SEED_DEFAULT = 32'hACE12468
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [REG_W-1:0]  latch_word_i,
  input  logic [REG_W-1:0]  noise_word_i
);
  // reset synchronizer: asserted asynchronously, released on the 2nd edge
  logic rst_meta_n, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  // address decode
  logic hit_rand, hit_ctrl, hit_wl, hit_wh, hit_rl, hit_rh, hit_lat, hit_noi;
  logic do_wr, do_rd;
  always_comb begin
    hit_rand = bus_addr == ADDR_W'(OFF_RAND);
    hit_ctrl = bus_addr == ADDR_W'(OFF_CTRL);
    hit_wl   = bus_addr == ADDR_W'(OFF_WBUF_L);
    hit_wh   = bus_addr == ADDR_W'(OFF_WBUF_H);
    hit_rl   = bus_addr == ADDR_W'(OFF_RBUF_L);
    hit_rh   = bus_addr == ADDR_W'(OFF_RBUF_H);
    hit_lat  = bus_addr == ADDR_W'(OFF_LATCH);
    hit_noi  = bus_addr == ADDR_W'(OFF_NOISE);
    do_wr    = bus_sel &  bus_write;
    do_rd    = bus_sel & ~bus_write;
  end

  // control and write buffers: next state
  ctrl_t             ctrl_q, ctrl_d;
  logic [REG_W-1:0]  wbuf_lo_q, wbuf_lo_d, wbuf_hi_q, wbuf_hi_d;
  logic              ctrl_en, wlo_en, whi_en;

  always_comb begin
    ctrl_en   = do_wr & hit_ctrl;
    wlo_en    = do_wr & hit_wl;
    whi_en    = do_wr & hit_wh;
    ctrl_d    = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    wbuf_lo_d = bus_wdata;
    wbuf_hi_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ctrl_q    <= '0;
      wbuf_lo_q <= '0;
      wbuf_hi_q <= '0;
    end else begin
      if (ctrl_en) ctrl_q    <= ctrl_d;
      if (wlo_en)  wbuf_lo_q <= wbuf_lo_d;
      if (whi_en)  wbuf_hi_q <= wbuf_hi_d;
    end
  end

  // generator
  logic             seed_wr, rand_rd, lfsr_step;
  logic [REG_W-1:0] lfsr_q;

  always_comb begin
    seed_wr   = do_wr & hit_rand;
    rand_rd   = do_rd & hit_rand;
    lfsr_step = ~ctrl_q.step_on_read | rand_rd;
  end

  rng_lfsr #(
    .W       (REG_W),
    .TAPS    (LFSR_TAPS),
    .DEFAULT (SEED_DEFAULT)
  ) lfsr_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load_en  (seed_wr),
    .load_val (bus_wdata),
    .step_en  (lfsr_step),
    .state    (lfsr_q)
  );

  // byte reversal
  logic [REG_W-1:0] swap_lo, swap_hi;

  rng_byteswap #(.W(REG_W)) swap_i (
    .wide    (ctrl_q.swap_wide),
    .lo_word (wbuf_lo_q),
    .hi_word (wbuf_hi_q),
    .rd_lo   (swap_lo),
    .rd_hi   (swap_hi)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (do_rd) begin
      if (hit_rand)     bus_rdata = lfsr_q;
      else if (hit_ctrl) bus_rdata = REG_W'(ctrl_q);
      else if (hit_wl)  bus_rdata = wbuf_lo_q;
      else if (hit_wh)  bus_rdata = wbuf_hi_q;
      else if (hit_rl)  bus_rdata = swap_lo;
      else if (hit_rh)  bus_rdata = swap_hi;
      else if (hit_lat) bus_rdata = latch_word_i;
      else if (hit_noi) bus_rdata = noise_word_i;
    end
  end
endmodule

// File: rtl/rng_swap_periph_chk.sv
module rng_swap_periph_chk #(
  parameter int          ADDR_W       = 32,
  parameter logic [31:0] SEED_DEFAULT = 32'hACE12468
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              bus_sel,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [31:0]       latch_word_i,
  input logic [31:0]       lfsr_state,
  input logic              step_on_read
);
  logic seed_wr, rand_rd, mapped;
  assign seed_wr = bus_sel & bus_write & (bus_addr == '0);
  assign rand_rd = bus_sel & ~bus_write & (bus_addr == '0);
  assign mapped  = (bus_addr[ADDR_W-1:5] == '0) && (bus_addr[1:0] == 2'b00);

  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (seed_wr && bus_wdata != '0) |=> lfsr_state == $past(bus_wdata)); // R4
  AST_ZERO_SEED: assert property (@(posedge clk) disable iff (!rst_core_n)
    (seed_wr && bus_wdata == '0) |=> lfsr_state == SEED_DEFAULT); // R4
  AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_core_n)
    lfsr_state != '0); // R4
  AST_HOLD_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (step_on_read && !seed_wr && !rand_rd) |=> $stable(lfsr_state)); // R3
  AST_FREE_MOVES: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!step_on_read && !seed_wr) |=> lfsr_state != $past(lfsr_state)); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_sel && !bus_write && !mapped) |-> bus_rdata == '0); // R10
  AST_LATCH_PASS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_sel && !bus_write && bus_addr == ADDR_W'(8'h18)) |-> bus_rdata == latch_word_i); // R9
endmodule

bind rng_swap_periph rng_swap_periph_chk #(
  .ADDR_W       (ADDR_W),
  .SEED_DEFAULT (SEED_DEFAULT)
) chk_i (
  .clk          (clk),
  .rst_core_n   (rst_core_n),
  .bus_sel      (bus_sel),
  .bus_write    (bus_write),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .latch_word_i (latch_word_i),
  .lfsr_state   (lfsr_q),
  .step_on_read (ctrl_q.step_on_read)
);

// File: tb/rng_swap_periph_tb.sv
module rng_swap_periph_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DEF  = 32'hACE12468;
  localparam logic [31:0] TAPS = 32'h80200003;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel, wr;
  logic [31:0] addr, wdata, rdata, latch_w, noise_w;

  int n_checks = 0;
  int n_fail   = 0;

  // reference state
  logic [31:0] m_lfsr = DEF;
  logic [5:0]  m_ctrl = '0;
  logic [31:0] m_lo   = '0;
  logic [31:0] m_hi   = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rng_swap_periph dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_write(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .latch_word_i(latch_w), .noise_word_i(noise_w)
  );

  function automatic logic [31:0] rev(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic logic [31:0] exp_read(input logic [31:0] a);
    case (a)
      32'h00: return m_lfsr;
      32'h04: return {26'd0, m_ctrl};
      32'h08: return m_lo;
      32'h0C: return m_hi;
      32'h10: return m_ctrl[1] ? rev(m_hi) : rev(m_lo);
      32'h14: return rev(m_lo);
      32'h18: return latch_w;
      32'h1C: return noise_w;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_update(input logic s, input logic w, input logic [31:0] a, input logic [31:0] d);
    logic [31:0] nxt;
    nxt = m_lfsr;
    if (s && w && a == 32'h0)           nxt = (d == 0) ? DEF : d;
    else if (!m_ctrl[0] || (s && !w && a == 32'h0))
      nxt = (m_lfsr >> 1) ^ (m_lfsr[0] ? TAPS : 32'h0);
    m_lfsr = nxt;
    if (s && w && a == 32'h04) m_ctrl = d[5:0];
    if (s && w && a == 32'h08) m_lo   = d;
    if (s && w && a == 32'h0C) m_hi   = d;
  endtask

  // called just after a falling edge; returns at the next falling edge
  task automatic cyc(input logic s, input logic w, input logic [31:0] a,
                     input logic [31:0] d, input string req, input bit upd);
    logic [31:0] e;
    sel = s; wr = w; addr = a; wdata = d;
    #1;
    if (s && !w) begin
      e = exp_read(a);
      n_checks++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rdata, e);
      end
    end
    if (upd) model_update(s, w, a, d);
    @(negedge clk);
  endtask

  task automatic rd(input logic [31:0] a, input string req);
    cyc(1'b1, 1'b0, a, 32'h0, req, 1'b1);
  endtask

  task automatic wt(input logic [31:0] a, input logic [31:0] d, input string req);
    cyc(1'b1, 1'b1, a, d, req, 1'b1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 32'h0, 32'h0, "idle", 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sel = 0; wr = 0; addr = 0; wdata = 0;
    latch_w = 32'hDEAD0001; noise_w = 32'h5A5A0002;
    repeat (3) @(negedge clk);
    // R1: reset values, model frozen while in reset
    cyc(1, 0, 32'h00, 0, "R1", 0);
    cyc(1, 0, 32'h04, 0, "R1", 0);
    cyc(1, 0, 32'h08, 0, "R1", 0);
    cyc(1, 0, 32'h0C, 0, "R1", 0);
    cyc(1, 0, 32'h10, 0, "R1", 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4 seed load, then R2 free-run stepping each clock
    wt(32'h00, 32'h12345678, "R4");
    for (int i = 0; i < 6; i++) rd(32'h00, "R2");
    idle(3);
    rd(32'h00, "R2");
    wt(32'h00, 32'h00000000, "R4");
    rd(32'h00, "R4");
    wt(32'h00, 32'h80000001, "R4");
    rd(32'h00, "R4");

    // R5 control storage and upper bits
    wt(32'h04, 32'h0000003F, "R5");
    rd(32'h04, "R5");
    wt(32'h04, 32'hFFFFFFC1, "R5");
    rd(32'h04, "R5");

    // R3 on-read stepping
    rd(32'h00, "R3");
    idle(5);
    rd(32'h00, "R3");
    rd(32'h00, "R3");
    rd(32'h04, "R3");
    rd(32'h00, "R3");
    wt(32'h00, 32'hCAFEF00D, "R4");
    rd(32'h00, "R4");
    rd(32'h00, "R3");

    // R6/R7/R8 buffers and reversal
    wt(32'h08, 32'h44332211, "R6");
    wt(32'h0C, 32'h88776655, "R6");
    rd(32'h08, "R6");
    rd(32'h0C, "R6");
    rd(32'h10, "R7");
    rd(32'h14, "R8");
    wt(32'h04, 32'h00000003, "R5");
    rd(32'h10, "R7");
    rd(32'h14, "R8");
    wt(32'h08, 32'hA1B2C3D4, "R6");
    rd(32'h10, "R7");
    rd(32'h14, "R8");

    // R9 pass-through
    rd(32'h18, "R9");
    rd(32'h1C, "R9");
    latch_w = 32'h0F0F1234; noise_w = 32'hF0F05678;
    rd(32'h18, "R9");
    rd(32'h1C, "R9");

    // R10 writes to read-only / unmapped, reads of unmapped
    wt(32'h10, 32'hFFFFFFFF, "R10");
    wt(32'h14, 32'hFFFFFFFF, "R10");
    wt(32'h18, 32'hFFFFFFFF, "R10");
    wt(32'h20, 32'hFFFFFFFF, "R10");
    rd(32'h08, "R10");
    rd(32'h0C, "R10");
    rd(32'h10, "R10");
    rd(32'h04, "R10");
    rd(32'h18, "R10");
    rd(32'h20, "R10");
    rd(32'h02, "R10");
    rd(32'h1000, "R10");
    rd(32'h00, "R10");

    // R2 again in free-run after returning bit 0 to zero
    wt(32'h04, 32'h00000002, "R5");
    for (int i = 0; i < 4; i++) rd(32'h00, "R2");

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule